// File: doc/BRIEF.md
# Ternary Match Table with Lowest-Address Priority

This block is a small ternary lookup table. Every entry holds a data word, a mask word of the same width, and a valid flag. A mask bit set to 1 makes that bit position a don't-care for that entry. A global mask register, shared by all entries, can also remove bit positions from every comparison. A search presents a key. One clock later the block returns whether any valid entry matched, whether more than one matched, and the index of the matching entry with the lowest address.

Entries are loaded and cleared through a single write port. They are inspected through a read port with one cycle of latency. The valid flags also drive a second priority encoder. That encoder reports the lowest-indexed empty entry and a full flag, so software can allocate slots without scanning the table. Depth and word width are parameters, with defaults of 64 entries and 136 bits.

Top module: `tcam_core`

## Requirements
- R1: A valid entry matches a key when every bit position with entry mask bit 0 has a key bit equal to the stored data bit. Positions with entry mask bit 1 are ignored.
- R2: A bit position whose global mask bit is 1 is ignored for every entry. `gm_wr` loads `gm_data` at the clock edge. Searches in later cycles use the new value, and the register resets to all zeros.
- R3: Only entries whose valid flag is 1 can match. A write with `wr_valid`=0 marks the entry empty, and it stops matching.
- R4: On a hit, `res_hit` is 1 and `res_addr` is the lowest index among the matching entries.
- R5: `res_multi` is 1 exactly when two or more entries match the search.
- R6: The results of a search with `srch_en`=1 appear after the next rising edge. `res_vld` is high for exactly that cycle. `res_hit`, `res_multi` and `res_addr` keep their values while no search is issued.
- R7: A search that matches nothing gives `res_hit`=0, `res_multi`=0 and `res_addr`=0.
- R8: `free_addr` is the lowest index whose valid flag is 0. `full` is 1 when every entry is valid, and `free_addr` is then 0. Both follow the valid flags without any added register.
- R9: A read with `rd_en`=1 returns the entry's data, mask and valid flag on `rd_data`, `rd_mask` and `rd_valid` after the next edge. These outputs hold while `rd_en`=0.
- R10: A synchronous reset (`rst_n`=0 at a rising edge) clears all valid flags, the global mask, all result outputs and all read outputs to 0.
- R11: A search issued in the same cycle as a write or a global mask write compares against the table and mask as they were before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write entry strobe |
| wr_addr | input | AW | Entry index to write |
| wr_data | input | WIDTH | Data word to store |
| wr_mask | input | WIDTH | Mask word to store (1 = don't-care) |
| wr_valid | input | 1 | Valid flag to store |
| rd_en | input | 1 | Read entry strobe |
| rd_addr | input | AW | Entry index to read |
| rd_data | output | WIDTH | Stored data word of the last read |
| rd_mask | output | WIDTH | Stored mask word of the last read |
| rd_valid | output | 1 | Stored valid flag of the last read |
| gm_wr | input | 1 | Global mask load strobe |
| gm_data | input | WIDTH | New global mask (1 = ignore bit) |
| srch_en | input | 1 | Search request |
| srch_key | input | WIDTH | Search key |
| res_vld | output | 1 | Search result strobe |
| res_hit | output | 1 | At least one entry matched |
| res_multi | output | 1 | Two or more entries matched |
| res_addr | output | AW | Lowest matching index |
| free_addr | output | AW | Lowest empty index |
| full | output | 1 | No empty entry remains |

## Verification
Search results and read data are due one edge after the request, so the reference model in the bench moves its expected result and read registers at the same edge as the design. It compares them at the following falling edge. The free-entry index and the full flag have no register of their own. The model therefore derives them from its valid flags as they stand after the edge, and it compares them in the same half cycle as the other outputs. Writes and global mask loads reach the model only after the search of that edge has been evaluated, which covers the same-cycle ordering in R11.

// File: rtl/tcam_pkg.sv
// Shared defaults for the ternary match table.
// Assumes: consumers derive address widths with $clog2 from ENTRIES.
package tcam_pkg;
    localparam int unsigned DEF_WIDTH   = 136;
    localparam int unsigned DEF_ENTRIES = 64;
endpackage

// File: rtl/tcam_lowest.sv
// Lowest-index priority encoder: reports whether any request bit is set
// and the index of the lowest one. Assumes: idx is 0 when no bit is set.
module tcam_lowest #(
    parameter int unsigned N  = 64,
    parameter int unsigned AW = 6
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [AW-1:0] idx
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = AW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/tcam_store.sv
// Entry storage: data, mask and valid flag per entry, one write port and
// a registered read port. Assumes: addresses are below ENTRIES; data and
// mask words are not reset, only the valid flags.
module tcam_store #(
    parameter int unsigned WIDTH   = 136,
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned AW      = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [AW-1:0]                   wr_addr,
    input  logic [WIDTH-1:0]                wr_data,
    input  logic [WIDTH-1:0]                wr_mask,
    input  logic                            wr_valid,
    input  logic                            rd_en,
    input  logic [AW-1:0]                   rd_addr,
    output logic [WIDTH-1:0]                rd_data,
    output logic [WIDTH-1:0]                rd_mask,
    output logic                            rd_valid,
    output logic [ENTRIES-1:0][WIDTH-1:0]   ent_data,
    output logic [ENTRIES-1:0][WIDTH-1:0]   ent_mask,
    output logic [ENTRIES-1:0]              ent_valid
);
    // Valid flags: cleared by reset, set or cleared by writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      ent_valid <= '0;
        else if (wr_en)  ent_valid[wr_addr] <= wr_valid;
    end

    // Data and mask words: loaded on writes.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_data[wr_addr] <= wr_data;
            ent_mask[wr_addr] <= wr_mask;
        end
    end

    // Read port: captures the addressed entry one edge after rd_en.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_mask  <= '0;
            rd_valid <= 1'b0;
        end else if (rd_en) begin
            rd_data  <= ent_data[rd_addr];
            rd_mask  <= ent_mask[rd_addr];
            rd_valid <= ent_valid[rd_addr];
        end
    end
endmodule

// File: rtl/tcam_match.sv
// Combinational ternary comparison of one key against every entry.
// Assumes: mask bit 1 (entry or global) marks a don't-care position.
module tcam_match #(
    parameter int unsigned WIDTH   = 136,
    parameter int unsigned ENTRIES = 64
) (
    input  logic [WIDTH-1:0]              key,
    input  logic [WIDTH-1:0]              gmask,
    input  logic [ENTRIES-1:0][WIDTH-1:0] ent_data,
    input  logic [ENTRIES-1:0][WIDTH-1:0] ent_mask,
    input  logic [ENTRIES-1:0]            ent_valid,
    output logic [ENTRIES-1:0]            hit
);
    // One comparator per entry.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit[i] = ent_valid[i] &
                        ~|((key ^ ent_data[i]) & ~(ent_mask[i] | gmask));
    end
endmodule

// File: rtl/tcam_core.sv
// Ternary match table top: global mask register, match array, two
// lowest-index encoders (matches and empty slots) and result registers.
// Assumes: one search, one write and one read may share a cycle; the
// search sees the table before that edge's write.
module tcam_core
    import tcam_pkg::*;
#(
    parameter int unsigned WIDTH   = DEF_WIDTH,
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    localparam int unsigned AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] wr_mask,
    input  logic             wr_valid,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] rd_mask,
    output logic             rd_valid,
    input  logic             gm_wr,
    input  logic [WIDTH-1:0] gm_data,
    input  logic             srch_en,
    input  logic [WIDTH-1:0] srch_key,
    output logic             res_vld,
    output logic             res_hit,
    output logic             res_multi,
    output logic [AW-1:0]    res_addr,
    output logic [AW-1:0]    free_addr,
    output logic             full
);
    logic [WIDTH-1:0]              gmask;
    logic [ENTRIES-1:0][WIDTH-1:0] ent_data;
    logic [ENTRIES-1:0][WIDTH-1:0] ent_mask;
    logic [ENTRIES-1:0]            ent_valid;
    logic [ENTRIES-1:0]            hit;
    logic                          hit_any;
    logic [AW-1:0]                 hit_idx;
    logic                          free_any;
    logic                          hit_many;

    // Global mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)     gmask <= '0;
        else if (gm_wr) gmask <= gm_data;
    end

    tcam_store #(.WIDTH(WIDTH), .ENTRIES(ENTRIES), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_mask(wr_mask), .wr_valid(wr_valid),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_mask(rd_mask), .rd_valid(rd_valid),
        .ent_data(ent_data), .ent_mask(ent_mask), .ent_valid(ent_valid)
    );

    tcam_match #(.WIDTH(WIDTH), .ENTRIES(ENTRIES)) u_match (
        .key(srch_key), .gmask(gmask),
        .ent_data(ent_data), .ent_mask(ent_mask), .ent_valid(ent_valid),
        .hit(hit)
    );

    tcam_lowest #(.N(ENTRIES), .AW(AW)) u_hit_enc (
        .req(hit), .any(hit_any), .idx(hit_idx)
    );

    tcam_lowest #(.N(ENTRIES), .AW(AW)) u_free_enc (
        .req(~ent_valid), .any(free_any), .idx(free_addr)
    );

    // Two or more hits: clearing the lowest set bit leaves something.
    assign hit_many = |(hit & (hit - ENTRIES'(1)));
    assign full     = ~free_any;

    // Result registers: updated only by a search, strobe every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld   <= 1'b0;
            res_hit   <= 1'b0;
            res_multi <= 1'b0;
            res_addr  <= '0;
        end else begin
            res_vld <= srch_en;
            if (srch_en) begin
                res_hit   <= hit_any;
                res_multi <= hit_many;
                res_addr  <= hit_idx;
            end
        end
    end
endmodule

// File: rtl/tcam_core_chk.sv
// Property checker for tcam_core, attached by bind.
module tcam_core_chk #(
    parameter int unsigned WIDTH = 136,
    parameter int unsigned AW    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             srch_en,
    input logic             res_vld,
    input logic             res_hit,
    input logic             res_multi,
    input logic [AW-1:0]    res_addr,
    input logic             rd_en,
    input logic [WIDTH-1:0] rd_data,
    input logic [WIDTH-1:0] rd_mask,
    input logic             wr_en,
    input logic             wr_valid,
    input logic [AW-1:0]    wr_addr,
    input logic [AW-1:0]    free_addr,
    input logic             full
);
    AST_RESULT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en |=> res_vld); // R6
    AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> !res_vld); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> ($stable(res_hit) && $stable(res_multi) && $stable(res_addr))); // R6
    AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        res_multi |-> res_hit); // R5
    AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_addr == '0)); // R7
    AST_FULL_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (free_addr == '0)); // R8
    AST_FREE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_valid && !full && wr_addr == free_addr) |=>
        (full || free_addr != $past(free_addr))); // R8
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(rd_data) && $stable(rd_mask))); // R9
endmodule

bind tcam_core tcam_core_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .srch_en(srch_en), .res_vld(res_vld),
    .res_hit(res_hit), .res_multi(res_multi), .res_addr(res_addr),
    .rd_en(rd_en), .rd_data(rd_data), .rd_mask(rd_mask),
    .wr_en(wr_en), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .free_addr(free_addr), .full(full)
);

// File: tb/tb_tcam_core.sv
module tb_tcam_core;
    localparam int W  = 136;
    localparam int N  = 64;
    localparam int AW = 6;

    logic clk = 0;
    logic rst_n = 0;
    logic wr_en = 0, wr_valid = 0, rd_en = 0, gm_wr = 0, srch_en = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [W-1:0]  wr_data = '0, wr_mask = '0, gm_data = '0, srch_key = '0;
    logic [W-1:0]  rd_data, rd_mask;
    logic          rd_valid, res_vld, res_hit, res_multi, full;
    logic [AW-1:0] res_addr, free_addr;

    always #2.5 clk = ~clk;

    tcam_core dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_mask(wr_mask), .wr_valid(wr_valid),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_mask(rd_mask), .rd_valid(rd_valid),
        .gm_wr(gm_wr), .gm_data(gm_data),
        .srch_en(srch_en), .srch_key(srch_key),
        .res_vld(res_vld), .res_hit(res_hit), .res_multi(res_multi),
        .res_addr(res_addr), .free_addr(free_addr), .full(full)
    );

    // Reference model state.
    logic [W-1:0] m_data [N];
    logic [W-1:0] m_mask [N];
    bit           m_valid [N];
    logic [W-1:0] m_gm = '0;
    bit           e_vld, e_hit, e_multi, e_rdv;
    int           e_addr;
    logic [W-1:0] e_rdd = '0, e_rdm = '0;
    bit           chk_on = 0;
    int           n_chk = 0, n_fail = 0;

    // Model: evaluate the search on pre-edge state, then apply updates (R11).
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_valid[i] = 0;
            m_gm = '0; e_vld = 0; e_hit = 0; e_multi = 0; e_addr = 0;
            e_rdd = '0; e_rdm = '0; e_rdv = 0;
        end else begin
            e_vld = srch_en;
            if (srch_en) begin
                int cnt; int first;
                cnt = 0; first = 0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (m_valid[i] &&
                        (((srch_key ^ m_data[i]) & ~m_mask[i] & ~m_gm) == '0)) begin
                        cnt++; first = i;
                    end
                end
                e_hit = cnt > 0; e_multi = cnt > 1; e_addr = (cnt > 0) ? first : 0;
            end
            if (rd_en) begin
                e_rdd = m_data[rd_addr]; e_rdm = m_mask[rd_addr]; e_rdv = m_valid[rd_addr];
            end
            if (wr_en) begin
                m_data[wr_addr] = wr_data; m_mask[wr_addr] = wr_mask;
                m_valid[wr_addr] = wr_valid;
            end
            if (gm_wr) m_gm = gm_data;
        end
    end

    // Compare every cycle at the falling edge.
    always @(negedge clk) begin
        if (chk_on) begin
            int ef; bit efull;
            ef = 0; efull = 1;
            for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) begin ef = i; efull = 0; end
            n_chk++;
            if (res_vld !== e_vld || res_hit !== e_hit || res_multi !== e_multi ||
                res_addr !== AW'(e_addr)) begin
                n_fail++;
                $display("FAIL R1-search R4 R5 R6 R7: vld/hit/multi/addr %b %b %b %0d expected %b %b %b %0d",
                         res_vld, res_hit, res_multi, res_addr, e_vld, e_hit, e_multi, e_addr);
            end
            n_chk++;
            if (free_addr !== AW'(ef) || full !== efull) begin
                n_fail++;
                $display("FAIL R8: free_addr/full %0d %b expected %0d %b", free_addr, full, ef, efull);
            end
            n_chk++;
            if (rd_data !== e_rdd || rd_mask !== e_rdm || rd_valid !== e_rdv) begin
                n_fail++;
                $display("FAIL R9: rd data/mask/valid %h %h %b expected %h %h %b",
                         rd_data, rd_mask, rd_valid, e_rdd, e_rdm, e_rdv);
            end
        end
    end

    function automatic logic [W-1:0] rnd();
        logic [159:0] v;
        v = {$urandom, $urandom, $urandom, $urandom, $urandom};
        return v[W-1:0];
    endfunction

    task automatic idle();
        wr_en = 0; rd_en = 0; gm_wr = 0; srch_en = 0;
    endtask
    task automatic tick();
        @(negedge clk); idle();
    endtask
    task automatic wr(input int a, input logic [W-1:0] d, input logic [W-1:0] m, input bit v);
        wr_en = 1; wr_addr = AW'(a); wr_data = d; wr_mask = m; wr_valid = v; tick();
    endtask
    task automatic srch(input logic [W-1:0] k);
        srch_en = 1; srch_key = k; tick();
    endtask
    task automatic rd(input int a);
        rd_en = 1; rd_addr = AW'(a); tick();
    endtask
    task automatic gmw(input logic [W-1:0] g);
        gm_wr = 1; gm_data = g; tick();
    endtask
    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        finish_run();
    end

    logic [W-1:0] A, B, C;
    initial begin
        A = rnd(); B = rnd(); C = rnd();
        // R10: reset state, checked while held in reset.
        @(posedge clk); @(negedge clk); chk_on = 1;
        repeat (2) @(negedge clk);
        rst_n = 1; @(negedge clk);
        // R1: exact entry and entry with low nibble masked.
        wr(0, A, '0, 1);
        wr(1, A, W'(4'hF), 1);
        wr(5, B, '0, 1);
        srch(A);                 // R5: entries 0 and 1 -> addr 0, multi
        srch(A ^ W'(1));         // R1: only masked entry 1 matches
        srch(B);                 // R4: entry 5
        srch(~B);                // R7: no hit
        tick(); tick();          // R6: results hold with no search
        // R2: global mask ignoring everything -> all valid entries match.
        gmw('1);
        srch(C);
        gmw('0);
        srch(C);                 // R2: mask cleared again -> miss
        // R3: clearing entry 0 removes it from searches and frees it.
        wr(0, A, '0, 0);
        srch(A);
        rd(1); rd(5); rd(0);     // R9
        tick();
        // R11: write and search in the same cycle sees the old table.
        wr_en = 1; wr_addr = 2; wr_data = C; wr_mask = '0; wr_valid = 1;
        srch_en = 1; srch_key = C; tick();
        srch(C);
        // R11: global mask load and search in the same cycle.
        gm_wr = 1; gm_data = '1; srch_en = 1; srch_key = rnd(); tick();
        gmw('0);
        // R8: fill every slot, then free one in the middle.
        for (int i = 0; i < N; i++) wr(i, rnd(), rnd() & rnd() & rnd(), 1);
        tick();
        wr(37, C, '0, 0);
        wr(37, C, '0, 1);
        // Mixed random traffic.
        for (int n = 0; n < 600; n++) begin
            int j;
            j = $urandom_range(N - 1);
            wr_en = ($urandom_range(3) == 0);
            wr_addr = AW'($urandom_range(N - 1));
            wr_data = rnd(); wr_mask = rnd() & rnd() & rnd();
            wr_valid = ($urandom_range(4) != 0);
            rd_en = $urandom_range(1); rd_addr = AW'($urandom_range(N - 1));
            gm_wr = ($urandom_range(15) == 0);
            gm_data = ($urandom_range(1) == 1) ? (rnd() & rnd() & rnd()) : '0;
            srch_en = ($urandom_range(2) != 0);
            srch_key = ($urandom_range(3) == 0) ? rnd() : (m_data[j] ^ (rnd() & rnd() & rnd() & rnd()));
            tick();
        end
        // R10: reset again mid-run.
        rst_n = 0; tick(); tick(); rst_n = 1; tick();
        srch(C);
        finish_run();
    end
endmodule